// File: doc/BRIEF.md
# DMA Page and Address Generator

This block holds the per-channel page registers of a four-channel DMA controller and turns a channel's 16-bit current address into a physical byte address. A small I/O port with a 3-bit offset reaches two banks of 8-bit page registers, a low bank and a high bank, which are chosen by a bank-select input. The offsets are tied to channels by a fixed map, and some offsets do not reach any channel.

When a request names a channel, the block takes three inputs from the surrounding controller: that channel's current address, its mode byte, and the byte position and access length of the transfer. It then forms the physical base from the two page registers and the current address, and counts up or down from that base as the mode selects. It also reports whether a memory access really happens, since verify transfers issue no access, and it passes on the channel's auto-initialization flag. The results are registered, and a one-cycle valid strobe marks each one.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Page port offsets select channels as follows: offset 1 is channel 2, offset 2 is channel 3, offset 3 is channel 1 and offset 7 is channel 0. This holds in both banks.
- R2: Offsets 0, 4, 5 and 6 reach no channel. A write to one of them changes no register, and a read from one returns 0.
- R3: Each channel has an 8-bit low page register (bank select `pg_hi_sel`=0) and an 8-bit high page register (`pg_hi_sel`=1). A write with `pg_we`=1 takes effect at the next clock edge. `pg_rdata` shows the addressed register in the same cycle.
- R4: The physical base is 31 bits wide. High page bits [6:0] sit at bits 30:24, the low page at bits 23:16 and the current address at bits 15:0. High page bit 7 is dropped.
- R5: When mode bit 5 is 0, the address is the base plus `req_pos`, taken modulo 2^31.
- R6: When mode bit 5 is 1, the address is the base minus `req_pos` minus `req_len`, taken modulo 2^31.
- R7: When mode bits [3:2] are 00, `out_mem_en` is 0 (verify transfer) and the address is still produced. For any other value of those bits, `out_mem_en` is 1.
- R8: `out_auto_init` equals mode bit 4 of the requested channel.
- R9: The results appear at the first clock edge after a cycle with `req_valid`=1. `out_valid` is high for that one cycle only, and it stays low when there is no request.
- R10: When the parameter `HIGH_PAGE_EN` is 0, the high bank reads as 0, ignores writes and adds nothing to the address.
- R11: After reset, every page register is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pg_we | input | 1 | Page register write strobe |
| pg_hi_sel | input | 1 | Bank select: 0 low page, 1 high page |
| pg_off | input | 3 | Page port offset |
| pg_wdata | input | 8 | Page write data |
| pg_rdata | output | 8 | Page read data (combinational) |
| ch_addr | input | 64 | Current address of each channel, 16 bits per channel, channel 0 in the low bits |
| ch_mode | input | 32 | Mode byte of each channel, channel 0 in the low bits |
| req_valid | input | 1 | Address request |
| req_chan | input | 2 | Requested channel |
| req_pos | input | 16 | Byte position within the transfer |
| req_len | input | 16 | Access length |
| out_valid | output | 1 | One-cycle result strobe |
| out_addr | output | 31 | Physical byte address |
| out_mem_en | output | 1 | A memory access is performed |
| out_auto_init | output | 1 | Channel auto-initialization flag |

## Verification
A page read is combinational, so the bench samples `pg_rdata` a quarter period after it drives the offset, in the same cycle. A page write lands at the next rising edge, so any read-back or request that relies on it comes after that edge. The address, memory-enable and auto-init outputs pass through one register: the bench holds a request over one rising edge and samples just after that edge. It then drops the request and checks one edge later that `out_valid` has fallen again.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

    // bit positions inside a channel mode byte
    localparam int MODE_W      = 8;
    localparam int MB_DEC      = 5;
    localparam int MB_AUTO     = 4;
    localparam int MB_XFER_HI  = 3;
    localparam int MB_XFER_LO  = 2;
    localparam int PORT_OFF_W  = 3;

    typedef struct packed {
        logic       hit;
        logic [1:0] chan;
    } pg_map_t;

    // fixed scramble of page port offsets onto channels
    function automatic pg_map_t pg_port_map(input logic [PORT_OFF_W-1:0] off);
        pg_map_t m;
        m = '{hit: 1'b0, chan: 2'd0};
        case (off)
            3'd1:    m = '{hit: 1'b1, chan: 2'd2};
            3'd2:    m = '{hit: 1'b1, chan: 2'd3};
            3'd3:    m = '{hit: 1'b1, chan: 2'd1};
            3'd7:    m = '{hit: 1'b1, chan: 2'd0};
            default: m = '{hit: 1'b0, chan: 2'd0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_pg_bank.sv
module dma_pg_bank
    import dma_pg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int PW     = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PORT_OFF_W-1:0]  off,
    input  logic [PW-1:0]          wdata,
    output logic [PW-1:0]          rdata,
    output logic [NCH*PW-1:0]      pages
);

    pg_map_t map;
    assign map = pg_port_map(off);

    generate
        if (ENABLE) begin : g_on
            typedef struct packed {
                logic [NCH-1:0][PW-1:0] pg;
            } bank_t;

            bank_t st_d, st_q;
            logic  ch_ok;

            assign ch_ok = map.hit && (int'(map.chan) < NCH);

            always_comb begin
                st_d = st_q;
                if (wr_en && ch_ok) begin
                    st_d.pg[map.chan] = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign pages = st_q.pg;
            assign rdata = ch_ok ? st_q.pg[map.chan] : '0;

            // R2
            unmapped_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !map.hit) |=> $stable(pages));

            // R2
            unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !map.hit |-> (rdata == '0));

            // R3
            mapped_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && ch_ok) |=> (pages[$past(map.chan)*PW +: PW] == $past(wdata)));
        end else begin : g_off
            assign pages = '0;
            assign rdata = '0;
        end
    endgenerate

endmodule

// File: rtl/dma_pg_addr_calc.sv
module dma_pg_addr_calc
    import dma_pg_pkg::*;
#(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter int HIW  = 7,
    parameter int POSW = 16
) (
    input  logic [PW-1:0]          lo_page,
    input  logic [PW-1:0]          hi_page,
    input  logic [AW-1:0]          cur_addr,
    input  logic [MODE_W-1:0]      mode,
    input  logic [POSW-1:0]        pos,
    input  logic [POSW-1:0]        len,
    output logic [HIW+PW+AW-1:0]   phys,
    output logic                   mem_en,
    output logic                   auto_init
);

    localparam int PHYS_W = HIW + PW + AW;

    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] pos_x;
    logic [PHYS_W-1:0] len_x;

    always_comb begin
        base  = {hi_page[HIW-1:0], lo_page, cur_addr};
        pos_x = PHYS_W'(pos);
        len_x = PHYS_W'(len);
        if (mode[MB_DEC]) begin
            phys = base - pos_x - len_x;
        end else begin
            phys = base + pos_x;
        end
        mem_en    = (mode[MB_XFER_HI:MB_XFER_LO] != 2'b00);
        auto_init = mode[MB_AUTO];
    end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dma_pg_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int AW           = 16,
    parameter int PW           = 8,
    parameter int HIW          = 7,
    parameter int POSW         = 16,
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pg_we,
    input  logic                        pg_hi_sel,
    input  logic [2:0]                  pg_off,
    input  logic [PW-1:0]               pg_wdata,
    output logic [PW-1:0]               pg_rdata,
    input  logic [NCH*AW-1:0]           ch_addr,
    input  logic [NCH*MODE_W-1:0]       ch_mode,
    input  logic                        req_valid,
    input  logic [$clog2(NCH)-1:0]      req_chan,
    input  logic [POSW-1:0]             req_pos,
    input  logic [POSW-1:0]             req_len,
    output logic                        out_valid,
    output logic [HIW+PW+AW-1:0]        out_addr,
    output logic                        out_mem_en,
    output logic                        out_auto_init
);

    localparam int PHYS_W = HIW + PW + AW;

    logic [NCH*PW-1:0] lo_pages, hi_pages;
    logic [PW-1:0]     lo_rd, hi_rd;

    dma_pg_bank #(.NCH(NCH), .PW(PW), .ENABLE(1'b1)) u_lo_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pg_we && !pg_hi_sel),
        .off   (pg_off),
        .wdata (pg_wdata),
        .rdata (lo_rd),
        .pages (lo_pages)
    );

    dma_pg_bank #(.NCH(NCH), .PW(PW), .ENABLE(HIGH_PAGE_EN)) u_hi_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pg_we && pg_hi_sel),
        .off   (pg_off),
        .wdata (pg_wdata),
        .rdata (hi_rd),
        .pages (hi_pages)
    );

    assign pg_rdata = pg_hi_sel ? hi_rd : lo_rd;

    // channel selection
    logic [PW-1:0]     sel_lo, sel_hi;
    logic [AW-1:0]     sel_addr;
    logic [MODE_W-1:0] sel_mode;

    assign sel_lo   = lo_pages[req_chan*PW +: PW];
    assign sel_hi   = hi_pages[req_chan*PW +: PW];
    assign sel_addr = ch_addr[req_chan*AW +: AW];
    assign sel_mode = ch_mode[req_chan*MODE_W +: MODE_W];

    logic [PHYS_W-1:0] calc_addr;
    logic              calc_mem, calc_auto;

    dma_pg_addr_calc #(.AW(AW), .PW(PW), .HIW(HIW), .POSW(POSW)) u_calc (
        .lo_page   (sel_lo),
        .hi_page   (sel_hi),
        .cur_addr  (sel_addr),
        .mode      (sel_mode),
        .pos       (req_pos),
        .len       (req_len),
        .phys      (calc_addr),
        .mem_en    (calc_mem),
        .auto_init (calc_auto)
    );

    typedef struct packed {
        logic              vld;
        logic [PHYS_W-1:0] addr;
        logic              mem;
        logic              auto_i;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_valid;
        if (req_valid) begin
            res_d.addr   = calc_addr;
            res_d.mem    = calc_mem;
            res_d.auto_i = calc_auto;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid     = res_q.vld;
    assign out_addr      = res_q.addr;
    assign out_mem_en    = res_q.mem;
    assign out_auto_init = res_q.auto_i;

    // R9
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    // R7
    verify_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_mem_en == ($past(sel_mode[MB_XFER_HI:MB_XFER_LO]) != 2'b00)));

    // R8
    auto_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_auto_init == $past(sel_mode[MB_AUTO])));

    // R9
    result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_addr));

    generate
        if (!HIGH_PAGE_EN) begin : g_nohi_chk
            // R10
            hi_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pg_hi_sel |-> (pg_rdata == '0));
        end
    endgenerate

endmodule

// File: tb/dma_page_addr_gen_test.sv
module dma_page_addr_gen_test;

    localparam int CLK_P = 10;
    localparam int VW    = 2 + 8 + 8 + 16 + 8 + 16 + 16;
    localparam int NV    = 8;

    // fields: chan, lo, hi, cur, mode, pos, len
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd2, 8'h12, 8'h34, 16'h5678, 8'h48, 16'h0010, 16'h0001},
        {2'd0, 8'hFF, 8'hFF, 16'hFFF0, 8'h44, 16'h0020, 16'h0001},
        {2'd3, 8'h00, 8'h00, 16'h0100, 8'h64, 16'h0010, 16'h0008},
        {2'd1, 8'hA0, 8'h01, 16'h1234, 8'h50, 16'h0000, 16'h0004},
        {2'd1, 8'h00, 8'h00, 16'h0000, 8'h28, 16'h0000, 16'h0001},
        {2'd2, 8'h55, 8'h80, 16'hAAAA, 8'hD8, 16'hFFFF, 16'h0002},
        {2'd0, 8'h10, 8'h02, 16'h8000, 8'h30, 16'h0100, 16'h0100},
        {2'd3, 8'h77, 8'h7F, 16'h0001, 8'h0C, 16'h0001, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_we = 1'b0, pg_hi_sel = 1'b0;
    logic [2:0]  pg_off = 3'd0;
    logic [7:0]  pg_wdata = 8'd0;
    logic [7:0]  pg_rdata, pg_rdata_n;
    logic [63:0] ch_addr = '0;
    logic [31:0] ch_mode = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = 2'd0;
    logic [15:0] req_pos = '0, req_len = '0;
    logic        out_valid, out_valid_n;
    logic [30:0] out_addr, out_addr_n;
    logic        out_mem_en, out_mem_en_n, out_auto_init, out_auto_init_n;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_page_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_hi_sel(pg_hi_sel),
        .pg_off(pg_off), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
        .ch_addr(ch_addr), .ch_mode(ch_mode), .req_valid(req_valid),
        .req_chan(req_chan), .req_pos(req_pos), .req_len(req_len),
        .out_valid(out_valid), .out_addr(out_addr), .out_mem_en(out_mem_en),
        .out_auto_init(out_auto_init)
    );

    dma_page_addr_gen #(.HIGH_PAGE_EN(1'b0)) uut_nohi (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_hi_sel(pg_hi_sel),
        .pg_off(pg_off), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata_n),
        .ch_addr(ch_addr), .ch_mode(ch_mode), .req_valid(req_valid),
        .req_chan(req_chan), .req_pos(req_pos), .req_len(req_len),
        .out_valid(out_valid_n), .out_addr(out_addr_n), .out_mem_en(out_mem_en_n),
        .out_auto_init(out_auto_init_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] chan_off(input logic [1:0] ch);
        case (ch)
            2'd0:    return 3'd7;
            2'd1:    return 3'd3;
            2'd2:    return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [30:0] model_addr(input logic [7:0] lo, input logic [7:0] hi,
        input logic [15:0] cur, input logic [7:0] mode, input logic [15:0] pos,
        input logic [15:0] len);
        logic [30:0] b;
        b = {hi[6:0], lo, cur};
        if (mode[5]) return b - 31'(pos) - 31'(len);
        return b + 31'(pos);
    endfunction

    task automatic pg_write(input logic hi, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        pg_hi_sel = hi; pg_off = off; pg_wdata = d; pg_we = 1'b1;
        @(negedge clk);
        pg_we = 1'b0;
    endtask

    task automatic pg_read(input logic hi, input logic [2:0] off, output logic [7:0] d,
        output logic [7:0] dn);
        @(negedge clk);
        pg_hi_sel = hi; pg_off = off;
        #(CLK_P/4);
        d = pg_rdata; dn = pg_rdata_n;
    endtask

    // one request; results sampled just after the capturing edge
    task automatic do_req(input logic [1:0] ch, input logic [15:0] pos, input logic [15:0] len);
        @(negedge clk);
        req_chan = ch; req_pos = pos; req_len = len; req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P*20000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd, rdn;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check("R11 out_valid after reset", 32'(out_valid), 32'd0);
        for (int o = 0; o < 8; o++) begin
            pg_read(1'b0, 3'(o), rd, rdn);
            check("R11 low page after reset", 32'(rd), 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        pg_read(1'b1, 3'd7, rd, rdn);
        check("R11 high page after reset", 32'(rd), 32'd0);

        // vector table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  ch;
            logic [7:0]  lo, hi, md;
            logic [15:0] cur, pos, len;
            {ch, lo, hi, cur, md, pos, len} = VEC[i];
            pg_write(1'b0, chan_off(ch), lo);
            pg_write(1'b1, chan_off(ch), hi);
            pg_read(1'b0, chan_off(ch), rd, rdn);
            check("R3 low page read back", 32'(rd), 32'(lo));
            pg_read(1'b1, chan_off(ch), rd, rdn);
            check("R3 high page read back", 32'(rd), 32'(hi));
            ch_addr[ch*16 +: 16] = cur;
            ch_mode[ch*8 +: 8]   = md;
            do_req(ch, pos, len);
            check("R9 out_valid pulse", 32'(out_valid), 32'd1);
            check(md[5] ? "R6 decrement address R4" : "R5 increment address R4",
                  32'(out_addr), 32'(model_addr(lo, hi, cur, md, pos, len)));
            check("R7 mem access flag", 32'(out_mem_en), 32'(md[3:2] != 2'b00));
            check("R8 auto init flag", 32'(out_auto_init), 32'(md[4]));
            @(posedge clk);
            #1;
            check("R9 out_valid single cycle", 32'(out_valid), 32'd0);
        end

        // R1 mapping: distinct low pages on each offset, observe through address
        pg_write(1'b0, 3'd1, 8'hC1);
        pg_write(1'b0, 3'd2, 8'hC2);
        pg_write(1'b0, 3'd3, 8'hC3);
        pg_write(1'b0, 3'd7, 8'hC7);
        ch_mode = '0;
        ch_addr = '0;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] e;
            e = (c == 0) ? 8'hC7 : (c == 1) ? 8'hC3 : (c == 2) ? 8'hC1 : 8'hC2;
            do_req(2'(c), 16'd0, 16'd0);
            check("R1 offset to channel map", 32'(out_addr[23:16]), 32'(e));
        end

        // R2 unmapped offsets
        for (int o = 0; o < 8; o++) begin
            if (o == 0 || o == 4 || o == 5 || o == 6) begin
                pg_write(1'b0, 3'(o), 8'h99);
                pg_read(1'b0, 3'(o), rd, rdn);
                check("R2 unmapped read zero", 32'(rd), 32'd0);
            end
        end
        pg_read(1'b0, 3'd1, rd, rdn);
        check("R2 mapped reg untouched off1", 32'(rd), 32'hC1);
        pg_read(1'b0, 3'd2, rd, rdn);
        check("R2 mapped reg untouched off2", 32'(rd), 32'hC2);
        pg_read(1'b0, 3'd3, rd, rdn);
        check("R2 mapped reg untouched off3", 32'(rd), 32'hC3);
        pg_read(1'b0, 3'd7, rd, rdn);
        check("R2 mapped reg untouched off7", 32'(rd), 32'hC7);

        // R10 high bank disabled
        pg_write(1'b1, 3'd1, 8'h3F);
        pg_read(1'b1, 3'd1, rd, rdn);
        check("R10 disabled high reads zero", 32'(rdn), 32'd0);
        check("R3 enabled high written", 32'(rd), 32'h3F);
        ch_mode[2*8 +: 8] = 8'h04;
        do_req(2'd2, 16'd0, 16'd0);
        check("R10 disabled high not in address", 32'(out_addr_n[30:24]), 32'd0);
        check("R4 high page in address", 32'(out_addr[30:24]), 32'h3F);

        // R9 no request keeps strobe low
        repeat (3) @(posedge clk);
        #1;
        check("R9 idle strobe low", 32'(out_valid), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule